// File: doc/BRIEF.md
# Staggered Output Switching Sequencer

This block drives the sink-enable lines of a bank of constant-current outputs and the shared enable of the pre-charge switch. Each channel's request is its on/off register bit qualified by the blanking input being low. The request reaches the output only after a delay that grows with the channel index. Switching events therefore spread over time instead of landing on one clock edge, which limits the inrush seen by the output supply. Turning on and turning off are both staggered in this way.

The pre-charge switch is common to all channels. It closes only after every channel that was lit, or was still on its way to being lit when blanking rose, has completed its delayed turn-off. It opens on the first clock edge at which blanking is sampled low, whatever the on/off data holds. A transition already in flight always completes at its own scheduled time, so each lit channel stays on for exactly as many cycles as blanking was low.

Top module: `stagger_output_seq`

## Requirements
- R1: While reset is sampled high, the clock edge clears every sink enable and the pre-charge enable to 0.
- R2: A channel's request is its on/off bit AND NOT blank. Channel 0's sink enable equals the request sampled at the same clock edge, one register stage, with no added delay.
- R3: Channel n's sink enable equals the request sampled n*STEP_CYCLES clock edges before channel 0's. Turn-on and turn-off use the same delay.
- R4: A request captured before blanking rose completes both its on and its off transition at its scheduled time. A channel whose bit is 1 throughout a blank-low window of L cycles is on for exactly L cycles.
- R5: While blank is high, the pre-charge enable becomes 1 on the first edge after which no channel is on and no request is still in flight. It then stays 1 for as long as blank stays high.
- R6: On any clock edge at which blank is sampled low, the pre-charge enable becomes 0, whatever the on/off data holds.
- R7: The pre-charge enable and any sink enable are never 1 at the same time.
- R8: A change of the on/off register while blank is low reaches each channel through that channel's own delay.
- R9: If no channel is on or in flight when blank is sampled high, the pre-charge enable is 1 after that same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| blank_in | input | 1 | Blanking: 1 turns all channels off and permits pre-charge |
| onoff_in | input | CH | On/off register, bit n belongs to channel n |
| sink_en_o | output | CH | Registered sink enable, bit n for channel n |
| precharge_en_o | output | 1 | Registered common pre-charge enable |

## Verification
The inputs sampled at clock edge k show up on channel 0 right after edge k. They show up on channel n right after edge k + n*STEP_CYCLES. The pre-charge enable after edge k depends on blank at edge k and on whether any request is still in flight. The bench drives inputs on the falling edge and records the request applied at each rising edge. Half a period after every rising edge it compares both outputs with the values that these latencies give. Window tests count the on-cycles of each channel across single blank-low windows of several lengths and compare them with the window length.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Number of register stages between the gated request and a channel output.
  function automatic int unsigned chan_depth(input int unsigned idx,
                                             input int unsigned step);
    return idx * step + 1;
  endfunction

endpackage

// File: rtl/stagger_delay_line.sv
module stagger_delay_line #(
  parameter int unsigned DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic busy_next
);

  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  generate
    if (DEPTH == 1) begin : g_single
      assign stage_d = din;
    end else begin : g_multi
      assign stage_d = {stage_q[DEPTH-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout      = stage_q[DEPTH-1];
  assign busy_next = |stage_d;

  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|stage_q) && !din) |=> !dout);

endmodule

// File: rtl/stagger_precharge_ctl.sv
module stagger_precharge_ctl (
  input  logic clk,
  input  logic rst,
  input  logic blank_in,
  input  logic any_busy_next,
  output logic precharge_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      precharge_en <= 1'b0;
    end else begin
      precharge_en <= blank_in && !any_busy_next;
    end
  end

  // R5
  precharge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_in && precharge_en) |=> precharge_en);

  // R6
  precharge_release_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_in |=> !precharge_en);

endmodule

// File: rtl/stagger_output_seq.sv
module stagger_output_seq #(
  parameter int unsigned CH          = 16,
  parameter int unsigned STEP_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blank_in,
  input  logic [CH-1:0] onoff_in,
  output logic [CH-1:0] sink_en_o,
  output logic          precharge_en_o
);

  import stagger_pkg::*;

  logic [CH-1:0] req;
  logic [CH-1:0] busy_vec;
  logic          any_busy;
  logic          armed_q;

  assign req      = onoff_in & {CH{~blank_in}};
  assign any_busy = |busy_vec;

  generate
    for (genvar n = 0; n < CH; n++) begin : g_chan
      localparam int unsigned DEPTH_N = chan_depth(n, STEP_CYCLES);
      stagger_delay_line #(
        .DEPTH(DEPTH_N)
      ) i_line (
        .clk      (clk),
        .rst      (rst),
        .din      (req[n]),
        .dout     (sink_en_o[n]),
        .busy_next(busy_vec[n])
      );
    end
  endgenerate

  stagger_precharge_ctl i_pre (
    .clk          (clk),
    .rst          (rst),
    .blank_in     (blank_in),
    .any_busy_next(any_busy),
    .precharge_en (precharge_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sink_en_o == '0 && !precharge_en_o));

  // R2
  chan0_latency_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (sink_en_o[0] == $past(onoff_in[0] && !blank_in)));

  // R7
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    precharge_en_o |-> (sink_en_o == '0));

endmodule

// File: tb/test_stagger_output_seq.sv
module test_stagger_output_seq;

  localparam int CH   = 16;
  localparam int STEP = 2;
  localparam int HMAX = 4096;

  logic          clk = 1'b0;
  logic          rst;
  logic          blank;
  logic [CH-1:0] onoff;
  logic [CH-1:0] sink_en;
  logic          pre_en;

  int checks = 0;
  int errors = 0;
  int edge_k = -1;
  string phase = "R1";

  logic [CH-1:0] hist   [HMAX];
  logic          blank_h[HMAX];
  logic          rst_h  [HMAX];
  int            on_cnt [CH];

  always #10 clk = ~clk;

  stagger_output_seq #(.CH(CH), .STEP_CYCLES(STEP)) i_stagger_output_seq (
    .clk           (clk),
    .rst           (rst),
    .blank_in      (blank),
    .onoff_in      (onoff),
    .sink_en_o     (sink_en),
    .precharge_en_o(pre_en)
  );

  function automatic logic [CH-1:0] exp_sink(input int k);
    logic [CH-1:0] v = '0;
    if (rst_h[k]) return '0;
    for (int n = 0; n < CH; n++) begin
      int j = k - n * STEP;
      if (j >= 0 && !rst_h[j]) v[n] = hist[j][n];
    end
    return v;
  endfunction

  function automatic logic exp_pre(input int k);
    if (rst_h[k] || !blank_h[k]) return 1'b0;
    for (int n = 0; n < CH; n++) begin
      for (int j = k - n * STEP; j <= k; j++) begin
        if (j >= 0 && hist[j][n]) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  task automatic tick(input logic [CH-1:0] oo, input logic bl, input logic rs);
    logic [CH-1:0] es;
    logic          ep;
    onoff = oo;
    blank = bl;
    rst   = rs;
    @(posedge clk);
    edge_k++;
    hist[edge_k]    = bl ? '0 : oo;
    blank_h[edge_k] = bl;
    rst_h[edge_k]   = rs;
    @(negedge clk);
    es = exp_sink(edge_k);
    ep = exp_pre(edge_k);
    checks++;
    if (sink_en !== es) begin
      errors++;
      $display("FAIL %s sink (R2 ch0 / R3 others / R1 reset) edge %0d: actual %h expected %h",
               phase, edge_k, sink_en, es);
    end
    checks++;
    if (pre_en !== ep) begin
      errors++;
      $display("FAIL %s precharge (%s) edge %0d: actual %b expected %b",
               phase, bl ? "R5/R9" : "R6", edge_k, pre_en, ep);
    end
    checks++;
    if (pre_en === 1'b1 && sink_en !== '0) begin
      errors++;
      $display("FAIL R7 exclusive edge %0d: actual sink %h expected 0", edge_k, sink_en);
    end
    for (int n = 0; n < CH; n++) on_cnt[n] += int'(sink_en[n]);
  endtask

  task automatic window(input logic [CH-1:0] oo, input int len);
    for (int n = 0; n < CH; n++) on_cnt[n] = 0;
    for (int i = 0; i < len; i++) tick(oo, 1'b0, 1'b0);
    for (int i = 0; i < CH * STEP + 6; i++) tick(oo, 1'b1, 1'b0);
    for (int n = 0; n < CH; n++) begin
      int want = oo[n] ? len : 0;
      checks++;
      if (on_cnt[n] != want) begin
        errors++;
        $display("FAIL R4 on-duration ch%0d: actual %0d expected %0d", n, on_cnt[n], want);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < HMAX; i++) begin
      hist[i] = '0; blank_h[i] = 1'b0; rst_h[i] = 1'b0;
    end
    rst = 1'b1; blank = 1'b1; onoff = '1;
    // R1: reset state
    phase = "R1";
    for (int i = 0; i < 3; i++) tick('1, 1'b1, 1'b1);
    // R9: idle, blank high -> precharge right after the first edge
    phase = "R9";
    for (int i = 0; i < 5; i++) tick('0, 1'b1, 1'b0);
    // R3/R5/R6: single ripple
    phase = "R3";
    for (int i = 0; i < 8; i++) tick(16'hA5A5, 1'b0, 1'b0);
    phase = "R5";
    for (int i = 0; i < 40; i++) tick(16'hA5A5, 1'b1, 1'b0);
    // R4: window lengths
    phase = "R4";
    for (int l = 1; l <= 6; l++) window(16'hFFFF >> (l - 1) | 16'h8001, l);
    window(16'h0000, 4);
    // R8: on/off changes while blank low
    phase = "R8";
    for (int p = 0; p < 8; p++) begin
      for (int i = 0; i < 7; i++) tick(16'h1357 << p ^ 16'hF0F0 >> p, 1'b0, 1'b0);
    end
    for (int i = 0; i < 40; i++) tick('0, 1'b1, 1'b0);
    // R5/R6: short blank pulse in the middle of a ripple
    phase = "R6";
    for (int i = 0; i < 4; i++) tick('1, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) tick('1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) tick('1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) tick('1, 1'b1, 1'b0);
    // Mixed pseudo-random sweep
    phase = "R8";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 1200; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tick(lf, (lf[3:0] > 4'd10), 1'b0);
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule